// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block drives one pulse-width-modulated output. An 8-bit period counter is stepped through a selectable prescaler. Two fine bits below it advance once per prescaled clock, and together they form a 10-bit timebase. Every period is four fine steps long for each count of the coarse counter, so the duty value has 10-bit resolution while the period is set in 8 bits.

Software writes the period, the upper eight duty bits, and a control byte through a small register write port. The control byte holds the two lowest duty bits, the prescale select and a run bit, and it may be written at any time. The duty value in use is a shadow copy that is reloaded only when the timebase wraps at the end of a period, so a duty change never cuts a pulse short or stretches it. Writing the control byte with the run bit low stops the timebase and forces the output low at once.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset `pwm_out` is 0 and stays 0 until the run bit has been set and a first period has completed.
- R2: With period value P and prescale factor S, rising edges of `pwm_out` are (P+1)·4·S clock cycles apart.
- R3: For a 10-bit duty value D with 1 ≤ D ≤ 4P+3, `pwm_out` is high for D·S cycles and then low for the rest of each period.
- R4: A latched duty value of 0 keeps `pwm_out` low for the whole period; the output is not set at the period boundary.
- R5: A latched duty value greater than 4P+3 is never matched, so `pwm_out` stays high continuously.
- R6: A duty write in the middle of a period does not change the current pulse. The new value applies from the next period boundary onward.
- R7: Control bits [3:2] select the prescale factor: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R8: A control write with bit 4 (run) at 0 drives `pwm_out` low on the next clock and resets the timebase. After run is set again, the output stays low for the first full period.
- R9: Register address 0 holds the period, address 1 holds duty bits [9:2], and address 2 is control: bits [1:0] are duty bits [1:0], bits [3:2] are the prescale select, and bit 4 is run. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output |

## Verification
The high-hold property assumes two things: the period register is not lowered below the running coarse count, and the timebase never wraps by natural overflow. The stimulus meets this by writing the period only while the run bit is low. Duty writes land early in a period, just after a rising edge. This places the mid-period update in a known pulse and keeps the two duty halves from straddling a boundary. The shadow-stability and rise-at-rollover properties assume nothing about the inputs.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_DUTY_HI = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_SPARE   = 2'd3
  } reg_sel_e;

  // terminal count of the prescaler for a 2-bit select
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = PRE_W'(0);
      2'b01:   pre_limit = PRE_W'(3);
      default: pre_limit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [TMR_W-1:0]        wr_data,
  output logic [TMR_W-1:0]        period_q,
  output logic [TMR_W+FINE_W-1:0] duty_q,
  output logic [1:0]              ps_sel_q,
  output logic                    run_q
);
  localparam int PS_LSB  = FINE_W;
  localparam int RUN_BIT = FINE_W + 2;

  logic [TMR_W-1:0]  period_d, hi_q, hi_d;
  logic [FINE_W-1:0] lo_q, lo_d;
  logic [1:0]        ps_d;
  logic              run_d;
  logic              en_period, en_hi, en_ctrl;

  always_comb begin
    en_period = wr_en && (wr_addr == SEL_PERIOD);
    en_hi     = wr_en && (wr_addr == SEL_DUTY_HI);
    en_ctrl   = wr_en && (wr_addr == SEL_CTRL);
    period_d  = en_period ? wr_data : period_q;
    hi_d      = en_hi ? wr_data : hi_q;
    lo_d      = en_ctrl ? wr_data[FINE_W-1:0] : lo_q;
    ps_d      = en_ctrl ? wr_data[PS_LSB+1:PS_LSB] : ps_sel_q;
    run_d     = en_ctrl ? wr_data[RUN_BIT] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      ps_sel_q <= '0;
      run_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      ps_sel_q <= ps_d;
      run_q    <= run_d;
    end
  end

  assign duty_q = {hi_q, lo_q};
endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [1:0]              ps_sel,
  input  logic [TMR_W-1:0]        period,
  output logic                    tick,
  output logic                    rollover,
  output logic [TMR_W+FINE_W-1:0] tb_nxt
);
  localparam int TB_W = TMR_W + FINE_W;

  logic [PRE_W-1:0] pre_q, pre_d, lim;
  logic [TB_W-1:0]  tb_q;
  logic             at_end;

  always_comb begin
    lim      = pre_limit(ps_sel);
    tick     = run && (pre_q == lim);
    at_end   = (tb_q[TB_W-1:FINE_W] == period) && (tb_q[FINE_W-1:0] == '1);
    rollover = tick && at_end;
    pre_d    = pre_q;
    tb_nxt   = tb_q;
    if (!run) begin
      pre_d  = '0;
      tb_nxt = '0;
    end else if (tick) begin
      pre_d  = '0;
      tb_nxt = rollover ? '0 : tb_q + TB_W'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tb_q  <= '0;
    end else begin
      pre_q <= pre_d;
      tb_q  <= tb_nxt;
    end
  end
endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              rollover,
  input  logic [DUTY_W-1:0] tb_nxt,
  input  logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] shadow_q,
  output logic              pwm_out
);
  logic [DUTY_W-1:0] shadow_d;
  logic              out_d;

  always_comb begin
    shadow_d = rollover ? duty : shadow_q;
    out_d    = pwm_out;
    if (!run)
      out_d = 1'b0;
    else if (rollover)
      out_d = (duty != '0);
    else if (tick && (tb_nxt == shadow_q))
      out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pwm_out  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      pwm_out  <= out_d;
    end
  end
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic              pwm_out
);
  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  period_q;
  logic [DUTY_W-1:0] duty_q, shadow_q, tb_nxt;
  logic [1:0]        ps_sel_q;
  logic              run_q, tick, rollover;

  pwm_dbuf_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_q(period_q), .duty_q(duty_q), .ps_sel_q(ps_sel_q), .run_q(run_q)
  );

  pwm_dbuf_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .ps_sel(ps_sel_q), .period(period_q),
    .tick(tick), .rollover(rollover), .tb_nxt(tb_nxt)
  );

  pwm_dbuf_outstage #(.DUTY_W(DUTY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .rollover(rollover),
    .tb_nxt(tb_nxt), .duty(duty_q), .shadow_q(shadow_q), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_q,
  input logic                    rollover,
  input logic [TMR_W-1:0]        period_q,
  input logic [TMR_W+FINE_W-1:0] duty_q,
  input logic [TMR_W+FINE_W-1:0] shadow_q,
  input logic                    pwm_out
);
  // R8: a stopped block has its output low one clock later
  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !pwm_out);

  // R4: a zero duty taken at the boundary leaves the output low
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && duty_q == '0) |=> !pwm_out);

  // R2: the output only rises on a period boundary
  p_rise_on_roll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(rollover));

  // R6: the shadow duty only changes at a boundary
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover |=> $stable(shadow_q));

  // R5: an unreachable duty keeps the output high while running
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out && run_q && $stable(period_q) && shadow_q > {period_q, {FINE_W{1'b1}}})
      |=> (pwm_out || !run_q));
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .rollover(rollover), .period_q(period_q),
  .duty_q(duty_q), .shadow_q(shadow_q), .pwm_out(pwm_out)
);

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit seen = 0;
  bit prev = 0;
  int last_rise = 0;
  int hi_cnt = 0;
  int    exp_hi[$];
  int    exp_per[$];
  string exp_req[$];

  always #5 clk = ~clk;

  pwm_dbuf u_pwm_dbuf (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                       .wr_data(wr_data), .pwm_out(pwm_out));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measures each pulse from rise to rise, compares with queue front
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      summary();
    end
    if (mon_on) begin
      if (pwm_out && !prev) begin
        if (seen && exp_hi.size() > 0) begin
          check(hi_cnt == exp_hi[0], exp_req[0], hi_cnt, exp_hi[0]);
          check(cyc - last_rise == exp_per[0], "R2", cyc - last_rise, exp_per[0]);
          void'(exp_hi.pop_front());
          void'(exp_per.pop_front());
          void'(exp_req.pop_front());
        end
        seen = 1;
        last_rise = cyc;
        hi_cnt = 0;
      end
      if (pwm_out) hi_cnt++;
    end else begin
      seen = 0;
    end
    prev = pwm_out;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input int duty, input logic [1:0] sel, input bit run);
    return {3'b000, run, sel, 2'(duty & 3)};
  endfunction

  task automatic configure(input int p, input int d, input logic [1:0] sel);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'(p));
    wr(2'd1, 8'(d >> 2));
    wr(2'd2, ctrl(d, sel, 1'b1));
  endtask

  // driver: push expected pulses
  task automatic expect_pulses(input int n, input int hi, input int per, input string req);
    for (int i = 0; i < n; i++) begin
      exp_hi.push_back(hi);
      exp_per.push_back(per);
      exp_req.push_back(req);
    end
  endtask

  task automatic drain(input string req);
    int waited = 0;
    while (exp_hi.size() > 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(exp_hi.size() == 0, req, exp_hi.size(), 0);
    exp_hi.delete(); exp_per.delete(); exp_req.delete();
    mon_on = 0;
  endtask

  task automatic wait_high();
    int w = 0;
    while (!pwm_out && w < 5000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic count_level(input int n, input bit lvl, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out != lvl) bad++;
    end
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    count_level(20, 1'b0, bad);
    check(bad == 0, "R1", bad, 0);

    // R3: basic, prescale 1
    configure(3, 5, 2'b00);
    mon_on = 1; expect_pulses(3, 5, 16, "R3"); drain("R3");

    // R7: prescale 4
    configure(7, 10, 2'b01);
    mon_on = 1; expect_pulses(2, 40, 128, "R7"); drain("R7");

    // R7: prescale 16 via select 11
    configure(2, 6, 2'b11);
    mon_on = 1; expect_pulses(2, 96, 192, "R7"); drain("R7");

    // R3: largest matched duty, one low cycle
    configure(2, 11, 2'b00);
    mon_on = 1; expect_pulses(3, 11, 12, "R3"); drain("R3");

    // R5: duty beyond period holds high
    configure(2, 12, 2'b00);
    wait_high();
    count_level(60, 1'b1, bad);
    check(bad == 0, "R5", bad, 0);

    // R4: zero duty suppresses the set
    configure(3, 8, 2'b00);
    wait_high();
    wr(2'd1, 8'h00);
    wr(2'd2, ctrl(0, 2'b00, 1'b1));
    repeat (40) @(negedge clk);
    count_level(64, 1'b0, bad);
    check(bad == 0, "R4", bad, 0);

    // R6: mid-period duty change applies next period
    configure(7, 8, 2'b00);
    mon_on = 1;
    expect_pulses(1, 8, 32, "R6");
    expect_pulses(2, 20, 32, "R6");
    wait_high();
    wr(2'd1, 8'd5);
    wr(2'd2, ctrl(20, 2'b00, 1'b1));
    drain("R6");

    // R8: stop forces low; first period after restart is low
    wait_high();
    wr(2'd2, 8'h00);
    @(negedge clk);
    check(pwm_out == 1'b0, "R8", pwm_out, 0);
    count_level(50, 1'b0, bad);
    check(bad == 0, "R8", bad, 0);
    wr(2'd2, ctrl(20, 2'b00, 1'b1));
    count_level(30, 1'b0, bad);
    check(bad == 0, "R8", bad, 0);

    // R9: spare address write ignored
    wr(2'd3, 8'h00);
    mon_on = 1; expect_pulses(2, 20, 32, "R9"); drain("R9");

    summary();
  end
endmodule